// File: doc/BRIEF.md
# General-Purpose Timer with Compare Channels

The block is a memory-mapped timer built around an up-counter that advances on prescaled ticks from one of several selectable tick sources. Software programs a divide ratio, loads one compare value per channel and enables an interrupt per channel. Each channel latches a sticky flag when the counter reaches its compare value. The single interrupt line is high while any enabled flag is set. Software clears flags by writing ones to the status register.

All tick sources are modelled as tick-enable inputs sampled on the one system clock. A control bit starts a self-timed software reset. That reset clears the timer state and keeps the clock-source choice. The counter either runs freely and wraps, or restarts from zero after a match on channel 0.

The register bus has a one-cycle write and a combinational read. Word addresses are CTRL=0, PRESCALE=1, STATUS=2, IRQ_ENABLE=3, COUNT=4, and COMPARE[i]=8+i. Unmapped addresses read as zero.

Top module: `gp_timer`

## Requirements
- R1: The counter advances once every PRESCALE+1 selected ticks. A PRESCALE value of 0 divides by one. Counting starts with the prescaler phase at zero, and the phase is held at zero while the run bit is clear.
- R2: CTRL[4:2] picks the tick source. Code 0 selects none. Codes 1 to 5 select src_ticks[0] to src_ticks[4]. Code 5 counts only while CTRL[5] (the fast-reference enable) is 1. Codes 6 and 7 select none.
- R3: Writing 1 to CTRL[15] starts a software reset. CTRL[15] reads 1 for SRST_CYCLES clock cycles and then reads 0. The reset clears the counter, prescale, status, interrupt enables, compare values, the run bit (CTRL[0]) and the mode bit (CTRL[1]). It keeps CTRL[5:2]. Bus writes made while the reset is in progress are ignored.
- R4: The counter changes only while the run bit CTRL[0] is 1. Writing 0 to CTRL stops the counter and clears the mode bit.
- R5: In free-run mode (CTRL[1]=0), a compare match does not disturb the counter, which wraps from all ones to 0.
- R6: In restart mode (CTRL[1]=1), when the counter equals COMPARE[0], the next prescaled tick loads 0. The count period is therefore COMPARE[0]+1 ticks.
- R7: STATUS bit i is set on the clock edge at which the counter takes a value equal to COMPARE[i].
- R8: Writing STATUS clears each bit written as 1 and leaves each bit written as 0 unchanged. If a match and a clear of the same bit land in one cycle, the bit stays set.
- R9: irq is 1 exactly while some STATUS bit i and IRQ_ENABLE bit i are both 1.
- R10: Reading COUNT returns the current count and has no side effects. PRESCALE, IRQ_ENABLE and COMPARE[i] read back the values written to them.
- R11: After rst_n is low at a clock edge, every register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_ticks | input | 5 | Tick enables for source codes 1..5 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write when 1, read when 0 |
| bus_addr | input | AW | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, combinational from bus_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the match-and-clear collision in one cycle. A design that gives the clear priority would drop that event and leave STATUS at zero. It checks the exact cycle a flag rises against a computed count, which exposes a flag set one tick early or late, or set from the old counter value. It programs a narrow counter width so it can observe wraparound, and it checks the restart period of COMPARE[0]+1. An off-by-one restart or a wrap that skips zero would show as a wrong count. It also writes registers while a software reset is in progress and reads the reset-busy bit cycle by cycle, which catches a reset that ends early or that lets those writes take effect.

// File: rtl/gpt_pkg.sv
// Shared register map, control layout and tick-source codes for the timer.
package gpt_pkg;
    localparam int REG_CTRL   = 0;
    localparam int REG_PRESC  = 1;
    localparam int REG_STATUS = 2;
    localparam int REG_IRQEN  = 3;
    localparam int REG_COUNT  = 4;
    localparam int REG_CMP0   = 8;

    localparam int CB_SWR     = 15;
    localparam int NUM_SRC    = 5;

    typedef enum logic [2:0] {
        SRC_NONE        = 3'd0,
        SRC_PERIPH      = 3'd1,
        SRC_PERIPH_FAST = 3'd2,
        SRC_EXT         = 3'd3,
        SRC_SLOW        = 3'd4,
        SRC_REF         = 3'd5
    } clk_src_e;

    // Bit 5 refen, bits 4:2 source, bit 1 restart mode, bit 0 run.
    typedef struct packed {
        logic     refen;
        clk_src_e src;
        logic     restart;
        logic     run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/gpt_tick_sel.sv
// Selects the tick source and divides it by presc+1.
// Assumes: ticks are single-cycle enables on clk; the phase is held at zero while stopped or cleared.
module gpt_tick_sel
    import gpt_pkg::*;
#(
    parameter int PS_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 run,
    input  clk_src_e             src,
    input  logic                 refen,
    input  logic [NUM_SRC-1:0]   src_ticks,
    input  logic [PS_W-1:0]      presc,
    output logic                 cnt_tick
);
    logic            base;
    logic            active;
    logic            wrap;
    logic [PS_W-1:0] phase_q;

    // Pick the raw tick for the selected source code.
    always_comb begin
        case (src)
            SRC_PERIPH:      base = src_ticks[0];
            SRC_PERIPH_FAST: base = src_ticks[1];
            SRC_EXT:         base = src_ticks[2];
            SRC_SLOW:        base = src_ticks[3];
            SRC_REF:         base = src_ticks[4] & refen;
            default:         base = 1'b0;
        endcase
    end

    assign active   = run & base & ~clr;
    assign wrap     = (phase_q >= presc);
    assign cnt_tick = active & wrap;

    // Advance the prescaler phase on each accepted raw tick.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !run)
            phase_q <= '0;
        else if (active)
            phase_q <= wrap ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/gpt_counter.sv
// Main up-counter: wraps in free-run mode, returns to zero after a channel-0 match in restart mode.
// Assumes: cnt_tick is already gated by run and clear.
module gpt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cnt_tick,
    input  logic             restart,
    input  logic [CNT_W-1:0] cmp0,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nxt
);
    // Value the counter takes on the next prescaled tick.
    always_comb begin
        if (restart && (count_q == cmp0))
            count_nxt = '0;
        else
            count_nxt = count_q + 1'b1;
    end

    // Hold or advance the count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            count_q <= '0;
        else if (cnt_tick)
            count_q <= count_nxt;
    end
endmodule

// File: rtl/gpt_cmp_chan.sv
// One compare channel: compare register plus a sticky, write-one-to-clear match flag.
// Assumes: a match is the counter entering the compare value; a set wins over a clear in the same cycle.
module gpt_cmp_chan #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             cnt_tick,
    input  logic [CNT_W-1:0] count_nxt,
    input  logic             w1c,
    output logic [CNT_W-1:0] cmp_q,
    output logic             flag_q
);
    logic hit;

    assign hit = cnt_tick && (count_nxt == cmp_q);

    // Compare value register.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cmp_q <= '0;
        else if (cmp_wr)
            cmp_q <= wdata;
    end

    // Sticky flag: a match sets it, a write of one clears it, and the set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (w1c)
            flag_q <= 1'b0;
    end
endmodule

// File: rtl/gp_timer.sv
// Timer top: register decode, control, software-reset sequencer, interrupt enables and read mux.
// Assumes: CNT_W and PS_W are at most DW; NCH fits the compare window of the address map.
module gp_timer
    import gpt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int PS_W        = 12,
    parameter int NCH         = 3,
    parameter int SRST_CYCLES = 4,
    parameter int AW          = 4,
    parameter int DW          = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_ticks,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [AW-1:0]      bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq
);
    localparam int SC_W = $clog2(SRST_CYCLES + 1);

    ctrl_t            ctrl_q;
    ctrl_t            wctrl;
    logic             srst_busy;
    logic [SC_W-1:0]  srst_cnt;
    logic             wr_ok;
    logic             wr_ctrl;
    logic             swr_req;
    logic             clr;
    logic [PS_W-1:0]  presc_q;
    logic [NCH-1:0]   irqen_q;
    logic [NCH-1:0]   status_q;
    logic [NCH-1:0]   w1c;
    logic             cnt_tick;
    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_nxt;
    logic [CNT_W-1:0] cmp_q [NCH];

    assign wr_ok   = bus_sel & bus_wr & ~srst_busy;
    assign wr_ctrl = wr_ok && (bus_addr == AW'(REG_CTRL));
    assign swr_req = wr_ctrl && bus_wdata[CB_SWR];
    assign clr     = swr_req | srst_busy;
    assign wctrl   = ctrl_t'(bus_wdata[CTRL_W-1:0]);
    assign w1c     = (wr_ok && (bus_addr == AW'(REG_STATUS))) ? bus_wdata[NCH-1:0] : '0;

    // Control register; a software-reset write keeps only the source and refen fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.src     <= wctrl.src;
            ctrl_q.refen   <= wctrl.refen;
            ctrl_q.run     <= wctrl.run & ~swr_req;
            ctrl_q.restart <= wctrl.restart & ~swr_req;
        end
    end

    // Software-reset sequencer: busy for SRST_CYCLES cycles after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_busy <= 1'b0;
            srst_cnt  <= '0;
        end else if (swr_req) begin
            srst_busy <= 1'b1;
            srst_cnt  <= SC_W'(SRST_CYCLES - 1);
        end else if (srst_busy) begin
            if (srst_cnt == '0)
                srst_busy <= 1'b0;
            else
                srst_cnt <= srst_cnt - 1'b1;
        end
    end

    // Prescale and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            presc_q <= '0;
            irqen_q <= '0;
        end else begin
            if (wr_ok && (bus_addr == AW'(REG_PRESC)))
                presc_q <= bus_wdata[PS_W-1:0];
            if (wr_ok && (bus_addr == AW'(REG_IRQEN)))
                irqen_q <= bus_wdata[NCH-1:0];
        end
    end

    gpt_tick_sel #(.PS_W(PS_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(ctrl_q.run),
        .src(ctrl_q.src), .refen(ctrl_q.refen), .src_ticks(src_ticks),
        .presc(presc_q), .cnt_tick(cnt_tick)
    );

    gpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .cnt_tick(cnt_tick),
        .restart(ctrl_q.restart), .cmp0(cmp_q[0]),
        .count_q(count_q), .count_nxt(count_nxt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        gpt_cmp_chan #(.CNT_W(CNT_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .cmp_wr(wr_ok && (bus_addr == AW'(REG_CMP0 + i))),
            .wdata(bus_wdata[CNT_W-1:0]), .cnt_tick(cnt_tick),
            .count_nxt(count_nxt), .w1c(w1c[i]),
            .cmp_q(cmp_q[i]), .flag_q(status_q[i])
        );
    end

    assign irq = |(status_q & irqen_q);

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(REG_CTRL)) begin
            bus_rdata[CTRL_W-1:0] = ctrl_q;
            bus_rdata[CB_SWR]     = srst_busy;
        end else if (bus_addr == AW'(REG_PRESC)) begin
            bus_rdata[PS_W-1:0] = presc_q;
        end else if (bus_addr == AW'(REG_STATUS)) begin
            bus_rdata[NCH-1:0] = status_q;
        end else if (bus_addr == AW'(REG_IRQEN)) begin
            bus_rdata[NCH-1:0] = irqen_q;
        end else if (bus_addr == AW'(REG_COUNT)) begin
            bus_rdata[CNT_W-1:0] = count_q;
        end
        for (int i = 0; i < NCH; i++)
            if (bus_addr == AW'(REG_CMP0 + i))
                bus_rdata[CNT_W-1:0] = cmp_q[i];
    end
endmodule

// File: rtl/gpt_checker.sv
// Property checker for the timer, bound to every gp_timer instance.
// Assumes: signal names of gp_timer internals as connected in the bind below.
module gpt_checker #(
    parameter int CNT_W = 32,
    parameter int NCH   = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic             run,
    input logic             restart,
    input logic             cnt_tick,
    input logic [CNT_W-1:0] count_q,
    input logic [CNT_W-1:0] cmp0,
    input logic [NCH-1:0]   status_q,
    input logic [NCH-1:0]   w1c,
    input logic [NCH-1:0]   irqen_q,
    input logic             irq
);
    // R1: no prescaled tick while stopped
    a_r1_no_tick_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !cnt_tick);

    // R3: software reset leaves counter and flags at zero
    a_r3_clear_state: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0) && (status_q == '0));

    // R4: counter holds while run is clear
    a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(count_q));

    // R5: free-run wrap to zero
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && !restart && !clr && (count_q == {CNT_W{1'b1}})) |=> (count_q == '0));

    // R6: restart reloads zero after channel-0 match
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && restart && !clr && (count_q == cmp0)) |=> (count_q == '0));

    // R8: a set flag not written with one stays set
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((status_q & $past(status_q & ~w1c)) == $past(status_q & ~w1c)));

    // R9: no interrupt with all enables clear
    a_r9_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (irqen_q == '0) |-> !irq);
endmodule

bind gp_timer gpt_checker #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
    .clk(clk), .rst_n(rst_n), .clr(clr), .run(ctrl_q.run),
    .restart(ctrl_q.restart), .cnt_tick(cnt_tick), .count_q(count_q),
    .cmp0(cmp_q[0]), .status_q(status_q), .w1c(w1c),
    .irqen_q(irqen_q), .irq(irq)
);

// File: tb/tb_gp_timer.sv
// Self-checking bench for gp_timer: fixed-seed random counts plus directed corner cases.
module tb_gp_timer;
    localparam int CW   = 10;
    localparam int NCH  = 3;
    localparam int SRST = 4;
    localparam int A_CTRL = 0, A_PRESC = 1, A_STAT = 2, A_IRQEN = 3, A_CNT = 4, A_CMP0 = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  src_ticks = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;

    gp_timer #(.CNT_W(CW), .PS_W(8), .NCH(NCH), .SRST_CYCLES(SRST), .AW(4), .DW(32)) dut (
        .clk(clk), .rst_n(rst_n), .src_ticks(src_ticks), .bus_sel(bus_sel),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #5 clk = ~clk;

    function automatic logic [31:0] ctrl_word(input bit run, input bit rst_mode,
                                              input int src, input bit refen, input bit swr);
        return (32'(swr) << 15) | (32'(refen) << 5) | (32'(src & 7) << 2)
             | (32'(rst_mode) << 1) | 32'(run);
    endfunction

    function automatic int exp_free(input int n, input int p);
        return (n / (p + 1)) % (1 << CW);
    endfunction

    function automatic int exp_restart(input int n, input int r);
        return n % (r + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, got, exp);
        end
    endtask

    // Called at a negedge; the write is taken at the next posedge.
    task automatic wr(input int addr, input logic [31:0] data);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'(addr); bus_wdata = data;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input int addr, output logic [31:0] data);
        bus_addr = 4'(addr);
        #1;
        data = bus_rdata;
    endtask

    task automatic soft_reset(input int src, input bit refen);
        wr(A_CTRL, ctrl_word(0, 0, src, refen, 1));
        repeat (SRST) @(negedge clk);
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: actual 0 expected 1 (run did not end)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset values
        rd_reg(A_CTRL, rd);  chk("R11 ctrl", rd, 0);
        rd_reg(A_CNT, rd);   chk("R11 count", rd, 0);
        rd_reg(A_STAT, rd);  chk("R11 status", rd, 0);
        chk("R11 irq", 32'(irq), 0);

        // R3: busy window, ignored write, kept source field
        src_ticks = 5'b11111;
        wr(A_CTRL, ctrl_word(1, 1, 1, 0, 1));
        rd_reg(A_CTRL, rd); chk("R3 busy at start", 32'(rd[15]), 1);
        wr(A_PRESC, 5);
        wait_cyc(SRST - 2);
        rd_reg(A_CTRL, rd); chk("R3 busy before end", 32'(rd[15]), 1);
        wait_cyc(1);
        rd_reg(A_CTRL, rd); chk("R3 busy released, src kept, run cleared", rd, ctrl_word(0, 0, 1, 0, 0));
        rd_reg(A_PRESC, rd); chk("R3 write during reset ignored", rd, 0);

        // R1, R4, R10: random prescale and run length
        for (int it = 0; it < 8; it++) begin
            int p = int'($urandom % 6);
            int n = int'($urandom % 40);
            soft_reset(1, 0);
            wr(A_PRESC, 32'(p));
            rd_reg(A_PRESC, rd); chk("R10 prescale readback", rd, 32'(p));
            wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
            wait_cyc(n);
            rd_reg(A_CNT, rd); chk("R1 prescaled count", rd, 32'(exp_free(n, p)));
            rd_reg(A_CNT, rd); chk("R10 count reread unchanged", rd, 32'(exp_free(n, p)));
            wr(A_CTRL, ctrl_word(0, 0, 1, 0, 0));
            wait_cyc(7);
            rd_reg(A_CNT, rd); chk("R4 stopped count holds", rd, 32'(exp_free(n + 1, p)));
        end
        wr(A_CTRL, ctrl_word(0, 1, 2, 1, 0));
        wr(A_CTRL, 0);
        rd_reg(A_CTRL, rd); chk("R4 zero write clears mode", rd, 0);

        // R2: each source code, only its own tick active
        for (int code = 0; code < 8; code++) begin
            for (int re = 0; re < 2; re++) begin
                int e;
                soft_reset(code, re[0]);
                src_ticks = (code >= 1 && code <= 5) ? 5'(1 << (code - 1)) : 5'b11111;
                wr(A_CTRL, ctrl_word(1, 0, code, re[0], 0));
                wait_cyc(10);
                e = (code >= 1 && code <= 4) ? 10 : (code == 5 && re == 1) ? 10 : 0;
                rd_reg(A_CNT, rd); chk("R2 source select", rd, 32'(e));
            end
        end
        src_ticks = 5'b11111;

        // R5: free-run wrap with a compare hit on the way
        for (int it = 0; it < 2; it++) begin
            int n = 1024 + int'($urandom % 80);
            soft_reset(1, 0);
            wr(A_CMP0, 32'd100);
            wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
            wait_cyc(n);
            rd_reg(A_CNT, rd); chk("R5 wrap count", rd, 32'(exp_free(n, 0)));
        end

        // R6: restart period
        for (int it = 0; it < 4; it++) begin
            int r = 3 + int'($urandom % 18);
            int n = int'($urandom % 90);
            soft_reset(1, 0);
            wr(A_CMP0, 32'(r));
            wr(A_CTRL, ctrl_word(1, 1, 1, 0, 0));
            wait_cyc(n);
            rd_reg(A_CNT, rd); chk("R6 restart count", rd, 32'(exp_restart(n, r)));
        end

        // R7, R8, R9: flag timing, clear, interrupt gating
        begin
            int c = 5 + int'($urandom % 25);
            soft_reset(1, 0);
            wr(A_CMP0 + 1, 32'(c));
            wr(A_CMP0 + 2, 32'd900);
            rd_reg(A_CMP0 + 1, rd); chk("R10 compare readback", rd, 32'(c));
            wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
            wait_cyc(c - 1);
            rd_reg(A_STAT, rd); chk("R7 flag clear before match", rd, 0);
            wait_cyc(1);
            rd_reg(A_STAT, rd); chk("R7 flag set on match", rd, 32'b010);
            wr(A_CTRL, ctrl_word(0, 0, 1, 0, 0));
            chk("R9 irq off when disabled", 32'(irq), 0);
            wr(A_IRQEN, 32'b001);
            chk("R9 irq off with other enable", 32'(irq), 0);
            wr(A_IRQEN, 32'b010);
            chk("R9 irq on", 32'(irq), 1);
            wr(A_STAT, 32'b101);
            rd_reg(A_STAT, rd); chk("R8 zero write keeps flag", rd, 32'b010);
            wr(A_STAT, 32'b010);
            rd_reg(A_STAT, rd); chk("R8 one write clears flag", rd, 0);
            chk("R9 irq drops after clear", 32'(irq), 0);
        end

        // R8: match and clear in the same cycle
        begin
            int c = 6 + int'($urandom % 20);
            soft_reset(1, 0);
            rd_reg(A_IRQEN, rd); chk("R3 irq enable cleared", rd, 0);
            rd_reg(A_CMP0 + 1, rd); chk("R3 compare cleared", rd, 0);
            wr(A_CMP0 + 2, 32'(c));
            wr(A_CTRL, ctrl_word(1, 0, 1, 0, 0));
            wait_cyc(c - 1);
            wr(A_STAT, 32'b100);
            rd_reg(A_STAT, rd); chk("R8 set wins over same-cycle clear", rd, 32'b100);
            wr(A_STAT, 32'b100);
            rd_reg(A_STAT, rd); chk("R8 later clear works", rd, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule